// File: doc/BRIEF.md
# Watchdog Timer Peripheral

This block is a watchdog timer that software reaches through a small memory-mapped register interface. It has two 32-bit word registers. The control/status word starts, stops and restarts the countdown, reports that the timer has expired, and chooses the action taken on expiry. The count word holds a 16-bit timeout, given in ticks. A prescaler divides the system clock down to one of four tick periods. When software triggers a reload, the programmed timeout is copied into a down-counter. While the timer runs, that counter loses one step on every tick.

When the countdown runs out, the block latches an expiry flag. It then sends a single-cycle request on either the reset output or the shutdown output. After that the counter stays at zero until software reloads it. A hardware disable input freezes the whole timer, and software can read the state of that input in the control word.

Top module: `wdog_timer`

## Requirements
- R1: After synchronous reset, the control word and the count word both read 0, with control bit 3 showing the disable input. Neither request output is high. The counter is not armed, so setting run without a reload never leads to expiry.
- R2: A bus write or read with bus_sel=1 reaches the control word at byte offset 0x0 and the count word at offset 0x4. The count word keeps only bits 15:0 of the written data, and its bits 31:16 read as 0.
- R3: The control word layout is: bit 0 run, bit 1 expiry flag, bit 2 action select (0 = reset, 1 = shutdown), bit 3 disable status, bit 7 reload trigger. Bits 6:4 are reserved: they read 0 and ignore writes. Bit 7 always reads 0.
- R4: A control write with bit 7 set copies the count word into the down-counter and restarts the tick phase, so the next tick falls one full tick period after the write. A write to the count word alone does not change a countdown that is already running.
- R5: With run=1, a timeout of N≥1 loaded at the clock edge of write E expires at edge E+N·L, where L is the tick period in cycles. A timeout of 0 expires on the first tick, at E+L.
- R6: The tick period is L = CLK_HZ/1 cycles for tick_res code 0 (1 s), CLK_HZ/10 for code 1, CLK_HZ/100 for code 2 and CLK_HZ/1000 for code 3.
- R7: On expiry, control bit 1 sets, and a pulse of exactly one cycle appears on reset_req when bit 2 is 0, or on shutdown_req when bit 2 is 1. It is visible after the same edge as the flag. The counter then holds at zero, and no further request comes until the next reload.
- R8: Writing 1 to control bit 1 clears the expiry flag, and writing 0 leaves it unchanged. The flag survives reloads. If an expiry and a clearing write fall on the same edge, the flag ends up set.
- R9: Clearing run stops the countdown and keeps the remaining count. Setting run again resumes from that count, with the tick phase starting again from zero.
- R10: While hw_disable is high, control bit 3 reads 1, the counter neither counts nor reloads, and no expiry occurs, whatever software writes to run and reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_res | input | 2 | Tick period select (0: 1 s, 1: 100 ms, 2: 10 ms, 3: 1 ms) |
| hw_disable | input | 1 | Hardware disable of the whole timer |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write enable, sampled with bus_sel |
| bus_addr | input | ADDR_W | Byte offset of the accessed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| reset_req | output | 1 | One-cycle reset request on expiry |
| shutdown_req | output | 1 | One-cycle shutdown request on expiry |

## Verification
Two pairs of functions can act on the same edge. In the first pair, a software write that clears the expiry flag can arrive on the very edge where the countdown expires. The bench provokes this by timing a clearing write to land exactly L cycles after a reload of timeout 1. It judges the result by checking that the request pulse still comes and that the flag reads back as set. In the second pair, a reload and a stop or resume can meet a tick. The scoreboard predicts the exact cycle of every request pulse from the reload edge, and any pulse that comes early, comes late, comes on the wrong output, or was not expected counts as an error.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int REG_W  = 32;
    localparam int CNT_W  = 16;

    // byte offsets of the two words
    localparam int OFS_CTRL  = 0;
    localparam int OFS_COUNT = 4;

    // control word bit positions
    localparam int B_RUN    = 0;
    localparam int B_FIRED  = 1;
    localparam int B_SHUT   = 2;
    localparam int B_DIS    = 3;
    localparam int B_RELOAD = 7;

    typedef enum logic [1:0] {
        RES_1S    = 2'd0,
        RES_100MS = 2'd1,
        RES_10MS  = 2'd2,
        RES_1MS   = 2'd3
    } tick_res_e;

    typedef struct packed {
        logic run;
        logic fired;
        logic shut_sel;
    } ctrl_t;

    // number of ticks per second for each resolution code
    function automatic int unsigned ticks_per_sec(input int code);
        case (code)
            0:       return 1;
            1:       return 10;
            2:       return 100;
            default: return 1000;
        endcase
    endfunction

    // assemble the control word as seen by a read
    function automatic logic [REG_W-1:0] ctrl_word(input ctrl_t c, input logic dis);
        logic [REG_W-1:0] w;
        w          = '0;
        w[B_RUN]   = c.run;
        w[B_FIRED] = c.fired;
        w[B_SHUT]  = c.shut_sel;
        w[B_DIS]   = dis;
        return w;
    endfunction

endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler
    import wdog_pkg::*;
#(
    parameter int unsigned CLK_HZ = 50_000_000
) (
    input  logic      clk,
    input  logic      rst,
    input  tick_res_e res_i,
    input  logic      active_i,
    input  logic      restart_i,
    output logic      tick_o
);

    localparam int DIV_W = $clog2(CLK_HZ + 1);
    localparam int N_RES = 4;

    logic [DIV_W-1:0] lim_tab [N_RES];
    logic [DIV_W-1:0] lim_m1;
    logic [DIV_W-1:0] pcnt_q;

    // one terminal count per resolution code
    for (genvar g = 0; g < N_RES; g++) begin : g_lim
        assign lim_tab[g] = DIV_W'(CLK_HZ / ticks_per_sec(g)) - DIV_W'(1);
    end

    assign lim_m1 = lim_tab[res_i];
    assign tick_o = active_i && (pcnt_q >= lim_m1);

    always_ff @(posedge clk) begin
        if (rst || !active_i || restart_i) begin
            pcnt_q <= '0;
        end else if (pcnt_q >= lim_m1) begin
            pcnt_q <= '0;
        end else begin
            pcnt_q <= pcnt_q + DIV_W'(1);
        end
    end

endmodule

// File: rtl/wdog_downcounter.sv
module wdog_downcounter
    import wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             tick_i,
    input  logic             dis_i,
    input  logic             shut_sel_i,
    output logic             expire_o,
    output logic             reset_req_o,
    output logic             shutdown_req_o
);

    logic [CNT_W-1:0] cnt_q;
    logic             spent_q;
    logic             load_eff;

    assign load_eff = load_i && !dis_i;
    assign expire_o = tick_i && !spent_q && !load_eff && (cnt_q <= CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            spent_q <= 1'b1;
        end else if (load_eff) begin
            cnt_q   <= load_val_i;
            spent_q <= 1'b0;
        end else if (tick_i && !spent_q) begin
            if (cnt_q <= CNT_W'(1)) begin
                cnt_q   <= '0;
                spent_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reset_req_o    <= 1'b0;
            shutdown_req_o <= 1'b0;
        end else begin
            reset_req_o    <= expire_o && !shut_sel_i;
            shutdown_req_o <= expire_o && shut_sel_i;
        end
    end

    // R10
    dis_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        dis_i |=> (cnt_q == $past(cnt_q)));

    // R5
    step_one_chk: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> ((cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) - CNT_W'(1))));

    // R7
    pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        (reset_req_o || shutdown_req_o) |=> !(reset_req_o || shutdown_req_o));

endmodule

// File: rtl/wdog_regfile.sv
module wdog_regfile
    import wdog_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    input  logic              hw_dis_i,
    input  logic              expire_i,
    output logic [REG_W-1:0]  rdata_o,
    output ctrl_t             ctrl_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              reload_o
);

    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] count_q;
    logic             hit_ctrl;
    logic             hit_count;
    logic             wr_ctrl;
    logic             wr_count;
    logic             unused_wbits;

    assign hit_ctrl  = (bus_addr == ADDR_W'(OFS_CTRL));
    assign hit_count = (bus_addr == ADDR_W'(OFS_COUNT));
    assign wr_ctrl   = bus_sel && bus_we && hit_ctrl;
    assign wr_count  = bus_sel && bus_we && hit_count;
    assign reload_o  = wr_ctrl && bus_wdata[B_RELOAD];

    assign unused_wbits = ^{bus_wdata[REG_W-1:CNT_W], bus_wdata[6:3]};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            count_q <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.run      <= bus_wdata[B_RUN];
                ctrl_q.shut_sel <= bus_wdata[B_SHUT];
            end
            // expiry wins over a clearing write on the same edge
            if (expire_i) begin
                ctrl_q.fired <= 1'b1;
            end else if (wr_ctrl && bus_wdata[B_FIRED]) begin
                ctrl_q.fired <= 1'b0;
            end
            if (wr_count) begin
                count_q <= bus_wdata[CNT_W-1:0];
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        if (hit_ctrl) begin
            rdata_o = ctrl_word(ctrl_q, hw_dis_i);
        end else if (hit_count) begin
            rdata_o = {{(REG_W-CNT_W){1'b0}}, count_q};
        end
    end

    assign ctrl_o  = ctrl_q;
    assign count_o = count_q;

    // R8
    fired_set_chk: assert property (@(posedge clk) disable iff (rst)
        expire_i |=> ctrl_q.fired);

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int unsigned CLK_HZ = 50_000_000,
    parameter int          ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        tick_res,
    input  logic              hw_disable,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              reset_req,
    output logic              shutdown_req
);

    ctrl_t            ctrl;
    logic [CNT_W-1:0] count_val;
    logic             reload;
    logic             expire;
    logic             tick;
    logic             active;

    assign active = ctrl.run && !hw_disable;

    wdog_regfile #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .hw_dis_i  (hw_disable),
        .expire_i  (expire),
        .rdata_o   (bus_rdata),
        .ctrl_o    (ctrl),
        .count_o   (count_val),
        .reload_o  (reload)
    );

    wdog_prescaler #(.CLK_HZ(CLK_HZ)) u_presc (
        .clk       (clk),
        .rst       (rst),
        .res_i     (tick_res_e'(tick_res)),
        .active_i  (active),
        .restart_i (reload),
        .tick_o    (tick)
    );

    wdog_downcounter u_cnt (
        .clk            (clk),
        .rst            (rst),
        .load_i         (reload),
        .load_val_i     (count_val),
        .tick_i         (tick),
        .dis_i          (hw_disable),
        .shut_sel_i     (ctrl.shut_sel),
        .expire_o       (expire),
        .reset_req_o    (reset_req),
        .shutdown_req_o (shutdown_req)
    );

    // R7
    one_action_chk: assert property (@(posedge clk) disable iff (rst)
        !(reset_req && shutdown_req));

    // R7
    req_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (reset_req || shutdown_req) |-> bus_rdata[B_FIRED] || !(bus_addr == ADDR_W'(OFS_CTRL)));

endmodule

// File: tb/wdog_timer_tb.sv
module wdog_timer_tb;

    localparam int CLK_HZ = 10_000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  tick_res = 2'd3;
    logic        hw_disable = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        reset_req;
    logic        shutdown_req;

    int nchk = 0;
    int nerr = 0;
    int cyc  = 0;

    typedef struct {
        bit    shut;
        int    at;
        string req;
    } exp_t;

    exp_t exp_q[$];

    wdog_timer #(.CLK_HZ(CLK_HZ)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .tick_res     (tick_res),
        .hw_disable   (hw_disable),
        .bus_sel      (bus_sel),
        .bus_we       (bus_we),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .reset_req    (reset_req),
        .shutdown_req (shutdown_req)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input longint act, input longint exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // caller is at a negedge; the write lands on the next posedge, returned in e
    task automatic wr(input logic [2:0] a, input logic [31:0] d, output int e);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        e = cyc;
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string req);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #2;
        chk(req, bus_rdata, exp);
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic wait_until(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic expect_req(input bit shut, input int at, input string req);
        exp_t it;
        it.shut = shut; it.at = at; it.req = req;
        exp_q.push_back(it);
    endtask

    // monitor: every request pulse must match the head of the queue
    always @(negedge clk) begin
        if (!rst && (reset_req || shutdown_req)) begin
            if (exp_q.size() == 0) begin
                nchk++; nerr++;
                $display("FAIL R7: actual unexpected request at cycle %0d expected none", cyc);
            end else begin
                exp_t it;
                it = exp_q.pop_front();
                chk(it.req, shutdown_req, it.shut);
                chk(it.req, reset_req, !it.shut);
                chk(it.req, cyc, it.at);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        int e, e1, e2;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1", {reset_req, shutdown_req}, 0);
        rd_chk(3'd0, 32'h0, "R1");
        rd_chk(3'd4, 32'h0, "R1");

        // R2 count word keeps 16 bits
        wr(3'd4, 32'h0001_2345, e);
        rd_chk(3'd4, 32'h0000_2345, "R2");
        // R3 reserved bits ignored
        wr(3'd0, 32'h0000_0070, e);
        rd_chk(3'd0, 32'h0, "R3");

        // R5/R4: timeout 3, count rewritten mid-run without reload
        wr(3'd4, 32'd3, e);
        wr(3'd0, 32'h81, e);
        expect_req(1'b0, e + 30, "R5");
        rd_chk(3'd0, 32'h01, "R3");
        wait_until(e + 14);
        wr(3'd4, 32'd9, e1);
        wait_until(e + 40);
        rd_chk(3'd0, 32'h03, "R7");
        wait_until(e + 140);

        // R8 fired persists across reload and write of 0
        wr(3'd4, 32'd2, e);
        wr(3'd0, 32'h81, e);
        expect_req(1'b0, e + 20, "R8");
        rd_chk(3'd0, 32'h03, "R8");
        wait_until(e + 25);
        wr(3'd0, 32'h03, e1);
        rd_chk(3'd0, 32'h01, "R8");

        // R7 shutdown action
        wr(3'd0, 32'h85, e);
        expect_req(1'b1, e + 20, "R7");
        wait_until(e + 25);
        rd_chk(3'd0, 32'h07, "R7");
        wr(3'd0, 32'h02, e1);
        rd_chk(3'd0, 32'h00, "R8");

        // R5 timeout of zero
        wr(3'd4, 32'd0, e);
        wr(3'd0, 32'h81, e);
        expect_req(1'b0, e + 10, "R5");
        wait_until(e + 15);
        wr(3'd0, 32'h02, e1);

        // R9 stop and resume
        wr(3'd4, 32'd5, e);
        wr(3'd0, 32'h81, e);
        wait_until(e + 24);
        wr(3'd0, 32'h00, e1);
        wait_until(e1 + 100);
        wr(3'd0, 32'h01, e2);
        expect_req(1'b0, e2 + 30, "R9");
        wait_until(e2 + 35);
        wr(3'd0, 32'h02, e1);

        // R8 expiry and clearing write on the same edge
        wr(3'd4, 32'd1, e);
        wr(3'd0, 32'h81, e);
        expect_req(1'b0, e + 10, "R8");
        wait_until(e + 9);
        wr(3'd0, 32'h03, e1);
        chk("R8", e1, e + 10);
        rd_chk(3'd0, 32'h03, "R8");
        wr(3'd0, 32'h02, e1);

        // R10 hardware disable
        hw_disable = 1'b1;
        rd_chk(3'd0, 32'h08, "R10");
        wr(3'd4, 32'd1, e);
        wr(3'd0, 32'h81, e);
        wait_until(e + 100);
        rd_chk(3'd0, 32'h09, "R10");
        hw_disable = 1'b0;
        wait_until(cyc + 50);
        rd_chk(3'd0, 32'h01, "R10");
        wr(3'd0, 32'h81, e);
        expect_req(1'b0, e + 10, "R10");
        wait_until(e + 15);

        // R6 tick resolutions
        tick_res = 2'd2;
        wr(3'd4, 32'd2, e);
        wr(3'd0, 32'h81, e);
        expect_req(1'b0, e + 200, "R6");
        wait_until(e + 205);
        tick_res = 2'd1;
        wr(3'd4, 32'd1, e);
        wr(3'd0, 32'h81, e);
        expect_req(1'b0, e + 1000, "R6");
        wait_until(e + 1005);
        tick_res = 2'd0;
        wr(3'd0, 32'h81, e);
        expect_req(1'b0, e + CLK_HZ, "R6");
        wait_until(e + CLK_HZ + 5);
        wr(3'd0, 32'h02, e1);
        wait_until(cyc + 20);

        // every expected pulse must have arrived
        chk("R5", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule